// File: doc/BRIEF.md
# Converter Output Code Formatter

This block is the digital tail of a 10-bit sampling converter. On every rising clock edge it takes one raw signed sample and a signed offset-correction value and adds them. If the sum leaves the 10-bit signed range, it pins the result to the nearest rail and marks the word as out of range. The corrected word and its flag then travel together through a fixed 12-stage delay line. At the far end the word is shown on a 10-bit bus, either as offset binary or as two's complement.

The output side has a valid strobe that marks words taken from real samples. It also has a drive-off control that floats the data bus and the flag. A power-down input forces every output to zero and empties the delay line. After power-down ends, valid words reappear only when fresh samples have crossed the whole pipeline.

Top module: `adcfmt_top`

## Requirements
- R1: A sample captured on a rising edge is shown on the outputs after the 12th rising edge, counting the capturing edge as the first. The falling edge does nothing.
- R2: The corrected value is the sum of `raw_smp` and `ofs_corr`, both read as signed two's complement. A sum within -512..511 passes through unchanged.
- R3: A sum above +511 is clamped to offset-binary code 0x3FF and its flag is set.
- R4: A sum below -512 is clamped to offset-binary code 0x000 and its flag is set. Clamping happens before format selection, so with `fmt_twos` high the two rails show as 0x1FF and 0x200.
- R5: With `fmt_twos` low the bus is offset binary, equal to value + 512: full positive 0x3FF, zero 0x200, minus one 0x1FF, full negative 0x000.
- R6: With `fmt_twos` high the bus is two's complement, which is offset binary with bit 9 inverted. The select acts on the bus in the same cycle, without pipeline delay.
- R7: The out-of-range flag stays aligned with its own word. It drops on the output one cycle after the last clamped word when the next word is in range.
- R8: While `drv_off` is high and `pwr_dn` is low, `code_out` and `oor_out` are high impedance and `dvalid` stays driven.
- R9: While `pwr_dn` is high, `code_out`, `oor_out` and `dvalid` are 0 in the same cycle, whatever `drv_off` is, and every pipeline stage is cleared on each rising edge.
- R10: `dvalid` is high only once 12 rising edges have passed with `pwr_dn` low since reset or since the last power-down.
- R11: The active-low asynchronous reset `rst_n` empties the pipeline: `dvalid` 0, `oor_out` 0, `code_out` 0x000 with offset-binary format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down: outputs forced to zero, pipeline flushed |
| drv_off | input | 1 | High floats the data bus and flag |
| fmt_twos | input | 1 | 0 offset binary, 1 two's complement |
| raw_smp | input | 10 | Raw signed sample |
| ofs_corr | input | 12 | Signed offset correction |
| code_out | output | 10 | Output code, bit 9 most significant |
| oor_out | output | 1 | Out-of-range flag of the shown word |
| dvalid | output | 1 | Shown word comes from a real sample |

## Verification
Sample-derived results (code, flag, valid) are due after the 12th rising edge, counting the capturing edge. Format select, drive-off and power-down act on the outputs within the same cycle. The bench keeps a 12-entry queue that it shifts on each rising edge, and it combines the queue head with the live control inputs. It compares every output on every falling edge, so each result is checked at the exact cycle it is due, never a cycle early or late. Power-down refills the queue with empty entries, which fixes when `dvalid` must come back.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;

   typedef enum logic {
      FMT_OFFSET = 1'b0,
      FMT_TWOS   = 1'b1
   } fmt_e;

   // width able to hold the sum of two sign-extended operands
   function automatic int sum_width(input int a_w, input int b_w);
      return ((a_w > b_w) ? a_w : b_w) + 1;
   endfunction

endpackage

// File: rtl/adcfmt_correct.sv
module adcfmt_correct #(
   parameter int DATA_W = 10,
   parameter int OFS_W  = 12
) (
   input  logic [DATA_W-1:0] raw_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [DATA_W-1:0] code_o,
   output logic              oor_o
);
   localparam int SUM_W = adcfmt_pkg::sum_width(DATA_W, OFS_W);
   localparam logic signed [SUM_W-1:0] POS_LIM = SUM_W'((2 ** (DATA_W - 1)) - 1);
   localparam logic signed [SUM_W-1:0] NEG_LIM = SUM_W'(-(2 ** (DATA_W - 1)));
   localparam logic [DATA_W-1:0]       MSB_BIT = DATA_W'(1) << (DATA_W - 1);

   logic signed [SUM_W-1:0] raw_x, ofs_x, sum;
   logic                    over, under;

   assign raw_x = SUM_W'($signed(raw_i));
   assign ofs_x = SUM_W'($signed(ofs_i));
   assign sum   = raw_x + ofs_x;
   assign over  = (sum > POS_LIM);
   assign under = (sum < NEG_LIM);

   // clamp first, then map signed value to offset binary
   always_comb begin
      if (over)       code_o = '1;
      else if (under) code_o = '0;
      else            code_o = sum[DATA_W-1:0] ^ MSB_BIT;
   end

   assign oor_o = over | under;

endmodule

// File: rtl/adcfmt_delay.sv
module adcfmt_delay #(
   parameter int W     = 12,
   parameter int DEPTH = 12
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         flush_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign q_o = d_i;
      end else begin : g_pipe
         logic [W-1:0] stg [DEPTH];
         for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
               always_ff @(posedge clk_i or negedge rst_ni) begin
                  if (!rst_ni)      stg[i] <= '0;
                  else if (flush_i) stg[i] <= '0;
                  else              stg[i] <= d_i;
               end
            end else begin : g_body
               always_ff @(posedge clk_i or negedge rst_ni) begin
                  if (!rst_ni)      stg[i] <= '0;
                  else if (flush_i) stg[i] <= '0;
                  else              stg[i] <= stg[i-1];
               end
            end
         end
         assign q_o = stg[DEPTH-1];
      end
   endgenerate

endmodule

// File: rtl/adcfmt_drive.sv
module adcfmt_drive #(
   parameter int DATA_W = 10
) (
   input  logic [DATA_W-1:0] code_i,
   input  logic              oor_i,
   input  logic              vld_i,
   input  logic              fmt_i,
   input  logic              pd_i,
   input  logic              off_i,
   output logic [DATA_W-1:0] code_o,
   output logic              oor_o,
   output logic              vld_o
);
   import adcfmt_pkg::*;

   localparam logic [DATA_W-1:0] MSB_BIT = DATA_W'(1) << (DATA_W - 1);

   fmt_e              mode;
   logic [DATA_W-1:0] conv;

   assign mode = fmt_e'(fmt_i);

   always_comb begin
      if (mode == FMT_TWOS) conv = code_i ^ MSB_BIT;
      else                  conv = code_i;
   end

   // power-down outranks the drive-off control
   assign code_o = pd_i ? '0   : (off_i ? 'z   : conv);
   assign oor_o  = pd_i ? 1'b0 : (off_i ? 1'bz : oor_i);
   assign vld_o  = pd_i ? 1'b0 : vld_i;

endmodule

// File: rtl/adcfmt_top.sv
module adcfmt_top #(
   parameter int DATA_W = 10,
   parameter int OFS_W  = 12,
   parameter int LAT    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_dn,
   input  logic              drv_off,
   input  logic              fmt_twos,
   input  logic [DATA_W-1:0] raw_smp,
   input  logic [OFS_W-1:0]  ofs_corr,
   output logic [DATA_W-1:0] code_out,
   output logic              oor_out,
   output logic              dvalid
);
   localparam int PW = DATA_W + 2;

   generate
      if (DATA_W < 2)     begin : g_bad_w   $error("DATA_W must be at least 2"); end
      if (OFS_W < 1)      begin : g_bad_o   $error("OFS_W must be at least 1"); end
      if (LAT < 1)        begin : g_bad_lat $error("LAT must be at least 1"); end
   endgenerate

   logic [DATA_W-1:0] corr_code;
   logic              corr_oor;
   logic [PW-1:0]     dly_d, dly_q;

   adcfmt_correct #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_correct (
      .raw_i  (raw_smp),
      .ofs_i  (ofs_corr),
      .code_o (corr_code),
      .oor_o  (corr_oor)
   );

   // packed word: {valid, flag, code}
   assign dly_d = {1'b1, corr_oor, corr_code};

   adcfmt_delay #(.W(PW), .DEPTH(LAT)) u_delay (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .flush_i (pwr_dn),
      .d_i     (dly_d),
      .q_o     (dly_q)
   );

   adcfmt_drive #(.DATA_W(DATA_W)) u_drive (
      .code_i (dly_q[DATA_W-1:0]),
      .oor_i  (dly_q[DATA_W]),
      .vld_i  (dly_q[DATA_W+1]),
      .fmt_i  (fmt_twos),
      .pd_i   (pwr_dn),
      .off_i  (drv_off),
      .code_o (code_out),
      .oor_o  (oor_out),
      .vld_o  (dvalid)
   );

endmodule

// File: rtl/adcfmt_chk.sv
module adcfmt_chk #(
   parameter int DATA_W = 10,
   parameter int LAT    = 12
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              pd_i,
   input logic              vld_o,
   input logic [DATA_W-1:0] corr_code,
   input logic              corr_oor,
   input logic [DATA_W+1:0] dly_q
);
   localparam int CW = $clog2(LAT + 1) + 1;

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 run_cnt <= '0;
      else if (pd_i)               run_cnt <= '0;
      else if (run_cnt < CW'(LAT)) run_cnt <= run_cnt + 1'b1;
   end

   // R3 R4: a flagged corrected word sits on a rail
   a_r3_corr_rail: assert property (@(posedge clk_i) disable iff (!rst_ni)
      corr_oor |-> (corr_code == '1 || corr_code == '0));

   // R7: flag leaving the pipeline still rides with a rail code
   a_r7_flag_with_rail: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dly_q[DATA_W] |-> (dly_q[DATA_W-1:0] == '1 || dly_q[DATA_W-1:0] == '0));

   // R9: power-down silences valid and flushes the pipeline
   a_r9_pd_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pd_i |-> !vld_o);

   a_r9_pd_flushed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(pd_i) |-> (dly_q == '0));

   // R10: valid exactly once a full pipeline of live samples has passed
   a_r10_valid_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pd_i |-> (vld_o == (run_cnt >= CW'(LAT))));

endmodule

bind adcfmt_top adcfmt_chk #(.DATA_W(DATA_W), .LAT(LAT)) u_chk (
   .clk_i     (clk),
   .rst_ni    (rst_n),
   .pd_i      (pwr_dn),
   .vld_o     (dvalid),
   .corr_code (corr_code),
   .corr_oor  (corr_oor),
   .dly_q     (dly_q)
);

// File: tb/adcfmt_top_bench.sv
`timescale 1ns/1ps
module adcfmt_top_bench;
   localparam int LAT = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_dn = 1'b0, drv_off = 1'b0, fmt_twos = 1'b0;
   logic [9:0] raw_smp = '0;
   logic [11:0] ofs_corr = '0;
   wire  [9:0] code_bus;
   wire        oor_w;
   wire        vld_w;

   int r_cur = 0, o_cur = 0;
   int total = 0, bad = 0;
   string tag = "R11";

   int q_code[$];
   bit q_oor[$];
   bit q_vld[$];

   always #2.5 clk = ~clk;

   // pull-ups make a floating bus read as all ones
   for (genvar i = 0; i < 10; i++) begin : g_pu
      pullup (code_bus[i]);
   end
   pullup (oor_w);

   adcfmt_top u_adcfmt_top (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .drv_off(drv_off),
      .fmt_twos(fmt_twos), .raw_smp(raw_smp), .ofs_corr(ofs_corr),
      .code_out(code_bus), .oor_out(oor_w), .dvalid(vld_w)
   );

   task automatic fill_empty();
      q_code.delete(); q_oor.delete(); q_vld.delete();
      for (int k = 0; k < LAT; k++) begin
         q_code.push_back(0); q_oor.push_back(1'b0); q_vld.push_back(1'b0);
      end
   endtask

   // reference: clamp, offset binary, 12-entry queue
   always @(posedge clk) begin
      if (!rst_n || pwr_dn) fill_empty();
      else begin
         int s;
         s = r_cur + o_cur;
         void'(q_code.pop_front()); void'(q_oor.pop_front()); void'(q_vld.pop_front());
         if (s > 511)       begin q_code.push_back(1023);    q_oor.push_back(1'b1); end
         else if (s < -512) begin q_code.push_back(0);       q_oor.push_back(1'b1); end
         else               begin q_code.push_back(s + 512); q_oor.push_back(1'b0); end
         q_vld.push_back(1'b1);
      end
   end

   task automatic chk(input string what, input logic [9:0] act, input logic [9:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (q_code.size() == LAT) begin
         logic [9:0] e_code;
         logic       e_oor, e_vld;
         if (pwr_dn) begin
            e_code = '0; e_oor = 1'b0; e_vld = 1'b0;
         end else begin
            e_vld = q_vld[0];
            if (drv_off) begin
               e_code = '1; e_oor = 1'b1;
            end else begin
               e_code = 10'(q_code[0]) ^ (fmt_twos ? 10'h200 : 10'h000);
               e_oor  = q_oor[0];
            end
         end
         chk("code", code_bus, e_code);
         chk("flag", {9'd0, oor_w}, {9'd0, e_oor});
         chk("valid", {9'd0, vld_w}, {9'd0, e_vld});
      end
   end

   task automatic put(input int r, input int o);
      @(posedge clk); #1;
      r_cur = r; o_cur = o;
      raw_smp = 10'(r); ofs_corr = 12'(o);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #500000;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   int bnd_r[10] = '{511, 511, 500, -512, -512, -300, 0, 0, 0, 0};
   int bnd_o[10] = '{0, 1, 2047, 0, -1, -2048, 511, 512, -512, -513};
   int alt_r[7]  = '{511, 0, 511, 511, 3, -512, -1};
   int alt_o[7]  = '{5, 0, 5, 5, 0, -9, 0};

   initial begin
      tag = "R11";
      repeat (4) put(0, 0);
      rst_n = 1'b1;
      tag = "R1 R2 R5 R10";
      for (int i = 0; i < 40; i++) put(((i * 37) % 1024) - 512, (i % 5) * 3 - 6);
      tag = "R6";
      fmt_twos = 1'b1;
      for (int i = 0; i < 24; i++) begin
         put(((i * 91) % 1024) - 512, i - 12);
         if (i % 3 == 2) fmt_twos = ~fmt_twos;
      end
      tag = "R3 R4";
      for (int f = 0; f < 2; f++) begin
         fmt_twos = f[0];
         for (int i = 0; i < 10; i++) put(bnd_r[i], bnd_o[i]);
         repeat (LAT) put(0, 0);
      end
      tag = "R7";
      fmt_twos = 1'b0;
      for (int i = 0; i < 7; i++) put(alt_r[i], alt_o[i]);
      repeat (LAT + 2) put(1, 1);
      tag = "R8";
      drv_off = 1'b1;
      for (int i = 0; i < 10; i++) put(i * 50 - 250, 0);
      drv_off = 1'b0;
      tag = "R9 R10";
      for (int i = 0; i < 6; i++) begin
         put(i * 20, 3);
         pwr_dn = 1'b1;
         drv_off = (i >= 3);
      end
      pwr_dn = 1'b0; drv_off = 1'b0;
      for (int i = 0; i < LAT + 8; i++) put(i * 11 - 100, -4);
      tag = "R1";
      repeat (LAT + 2) put(-512, 1023);
      @(negedge clk); @(posedge clk);
      finish_run();
   end

endmodule